// File: doc/BRIEF.md
# Fractional-N Feedback Divide Sequencer

This block produces, on every tick of the divider output clock, the integer divide value that a programmable feedback counter in a fractional-N PLL should use for its next cycle. Software-visible control words set an integer part, a fractional numerator and a fractional modulus. A cascade of three modulus accumulators shapes the fractional part into a dithered sequence of small integer offsets around the integer part. The long-run average divide ratio is therefore the integer part plus the numerator over the modulus.

The control words are captured only when the load strobe is high. At that point a prescaler-select input sets the legal integer range, and the numerator and modulus are checked as well. A word set that fails the check is refused and raises an error flag. The block keeps the words it already holds. An integer-mode flag, combined with a zero numerator, freezes the dither so that the output is the integer part on every cycle.

Top module: `fracn_divctl`

## Requirements
- R1: After an accepted load with modulus M and numerator F, the sum of `div_o` over any window of L = M*M*M consecutive steps that starts at the third step after the load equals INT*L + F*L/M.
- R2: While reset is asserted and after it is released, `div_o` is 100 and `cfg_err_o` is 0. The held words are INT = 100, FRAC = 0, MOD = 2, with integer mode on.
- R3: Every output lies in the range INT-3 to INT+4. Each accumulator always holds a value below the held modulus.
- R4: With `psel_i` = 0 (4/5 prescaler) INT must lie in 23..32767. With `psel_i` = 1 (8/9 prescaler) INT must lie in 75..65535. A strobe outside the range is refused.
- R5: FRAC must be at most MOD-1. A strobe with FRAC >= MOD is refused.
- R6: MOD must be at least 2, and its 12-bit field caps it at 4095. A strobe with MOD below 2 is refused.
- R7: On a refused strobe, `cfg_err_o` reads 1 one edge later and the held words are unchanged. The sequence advances exactly as it would on a cycle without a strobe.
- R8: When the held integer-mode flag is 1 and the held FRAC is 0, `div_o` equals INT on every cycle. When the flag is 1 and FRAC is non-zero, the output dithers normally.
- R9: On an accepted strobe, `div_o` equals the new INT one edge later. All accumulators and delayed carries are cleared, and `cfg_err_o` returns to 0.
- R10: Each step updates accumulator 1 with FRAC, accumulator 2 with the new value of accumulator 1, and accumulator 3 with the new value of accumulator 2. A stage whose sum reaches MOD subtracts MOD and gives carry 1, otherwise carry 0. The output is INT + c1 + c2 - c2' + c3 - 2*c3' + c3'', where the primed values are the carries of one and two steps earlier.
- R11: `cfg_err_o` changes only on an edge where the load strobe is high.
- R12: Changes of `int_i`, `frac_i`, `mod_i`, `psel_i` and `imode_i` without a strobe have no effect on `div_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider output tick; one step per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for the control words |
| psel_i | input | 1 | Prescaler select: 0 = 4/5, 1 = 8/9 |
| imode_i | input | 1 | Integer-mode flag |
| int_i | input | 16 | Integer part of the divide ratio |
| frac_i | input | 12 | Fractional numerator |
| mod_i | input | 12 | Fractional modulus |
| div_o | output | 17 | Divide value for the next counter cycle |
| cfg_err_o | output | 1 | Last strobe was refused |

## Verification
Every result of this block appears one edge after its cause. A strobe shows its new integer or its error flag after the edge that sampled it, and each dither step changes `div_o` once per edge. The bench advances a behavioural model on each rising edge from the same inputs. It compares `div_o` and `cfg_err_o` with that model at the following falling edge, so each comparison sees the value due for that step. The average-ratio checks sum `div_o` over a full modulus-cubed window that starts two steps after the load has been seen, and this keeps the first delayed-carry terms out of the sum.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

   typedef enum logic {
      PSC_4_5 = 1'b0,
      PSC_8_9 = 1'b1
   } psc_e;

   // offset of a third-order cascade spans -3..+4
   typedef logic signed [3:0] ofs_t;

   function automatic ofs_t bit2ofs(input logic b);
      return ofs_t'({3'b000, b});
   endfunction

endpackage

// File: rtl/fracn_cfg_chk.sv
module fracn_cfg_chk
   import fracn_pkg::*;
#(
   parameter int INT_W   = 16,
   parameter int MOD_W   = 12,
   parameter int P45_MIN = 23,
   parameter int P45_MAX = 32767,
   parameter int P89_MIN = 75,
   parameter int P89_MAX = 65535,
   parameter int MOD_MIN = 2
) (
   input  logic             psel_i,
   input  logic [INT_W-1:0] int_i,
   input  logic [MOD_W-1:0] frac_i,
   input  logic [MOD_W-1:0] mod_i,
   output logic             ok_o
);
   int  lo_lim;
   int  hi_lim;
   logic int_ok;
   logic mod_ok;
   logic frac_ok;

   always_comb begin
      if (psel_i == PSC_8_9) begin
         lo_lim = P89_MIN;
         hi_lim = P89_MAX;
      end else begin
         lo_lim = P45_MIN;
         hi_lim = P45_MAX;
      end
      int_ok  = (int'(int_i) >= lo_lim) && (int'(int_i) <= hi_lim);
      mod_ok  = int'(mod_i) >= MOD_MIN;
      frac_ok = frac_i < mod_i;
      ok_o    = int_ok && mod_ok && frac_ok;
   end

endmodule

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
   parameter int MOD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [MOD_W-1:0] inc_i,
   input  logic [MOD_W-1:0] mod_i,
   output logic [MOD_W-1:0] acc_o,
   output logic [MOD_W-1:0] res_o,
   output logic             carry_o
);
   localparam int SUM_W = MOD_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] wrapped;

   assign sum     = {1'b0, acc_o} + {1'b0, inc_i};
   assign wrapped = sum - {1'b0, mod_i};
   assign carry_o = sum >= {1'b0, mod_i};
   assign res_o   = carry_o ? wrapped[MOD_W-1:0] : sum[MOD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_o <= '0;
      else if (clr_i) acc_o <= '0;
      else if (adv_i) acc_o <= res_o;
   end

endmodule

// File: rtl/fracn_ofs_comb.sv
module fracn_ofs_comb
   import fracn_pkg::*;
#(
   parameter int ORDER = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [ORDER-1:0] carry_i,
   output ofs_t             ofs_o
);
   if (ORDER == 1) begin : g_ord1
      assign ofs_o = bit2ofs(carry_i[0]);
   end else if (ORDER == 2) begin : g_ord2
      logic c2_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     c2_d <= 1'b0;
         else if (clr_i) c2_d <= 1'b0;
         else if (adv_i) c2_d <= carry_i[1];
      end
      assign ofs_o = bit2ofs(carry_i[0]) + bit2ofs(carry_i[1]) - bit2ofs(c2_d);
   end else begin : g_ord3
      logic c2_d;
      logic c3_d1;
      logic c3_d2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
         end else if (clr_i) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
         end else if (adv_i) begin
            c2_d  <= carry_i[1];
            c3_d1 <= carry_i[2];
            c3_d2 <= c3_d1;
         end
      end
      assign ofs_o = bit2ofs(carry_i[0])
                   + bit2ofs(carry_i[1]) - bit2ofs(c2_d)
                   + bit2ofs(carry_i[2]) - (bit2ofs(c3_d1) <<< 1) + bit2ofs(c3_d2);
   end

endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
   import fracn_pkg::*;
#(
   parameter int INT_W   = 16,
   parameter int MOD_W   = 12,
   parameter int ORDER   = 3,
   parameter int P45_MIN = 23,
   parameter int P45_MAX = 32767,
   parameter int P89_MIN = 75,
   parameter int P89_MAX = 65535,
   parameter int MOD_MIN = 2,
   parameter int RST_INT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             psel_i,
   input  logic             imode_i,
   input  logic [INT_W-1:0] int_i,
   input  logic [MOD_W-1:0] frac_i,
   input  logic [MOD_W-1:0] mod_i,
   output logic [INT_W:0]   div_o,
   output logic             cfg_err_o
);
   localparam int DIV_W = INT_W + 1;
   localparam bit PARAMS_OK = (ORDER >= 1) && (ORDER <= 3)
                           && (MOD_W >= 2) && (INT_W >= 4) && (INT_W <= 30)
                           && (MOD_MIN >= 2) && (MOD_MIN < (1 << MOD_W))
                           && (P45_MAX < (1 << INT_W)) && (P89_MAX < (1 << INT_W))
                           && (P45_MIN >= 3) && (P89_MIN >= 3)
                           && (RST_INT >= P45_MIN) && (RST_INT <= P45_MAX);

   if (!PARAMS_OK) begin : g_bad_params
      $error("fracn_divctl: parameter set out of range");
   end

   // held control words
   logic [INT_W-1:0] int_q;
   logic [MOD_W-1:0] frac_q;
   logic [MOD_W-1:0] mod_q;
   logic             imode_q;
   logic             err_q;
   logic [DIV_W-1:0] div_q;

   logic cfg_ok;
   logic load_ok;
   logic bypass;
   logic step_en;

   logic [ORDER-1:0][MOD_W-1:0] acc_q;
   logic [ORDER-1:0][MOD_W-1:0] res_nxt;
   logic [ORDER-1:0]            carry;
   ofs_t                        ofs;
   logic signed [DIV_W:0]       div_s;

   fracn_cfg_chk #(
      .INT_W  (INT_W),
      .MOD_W  (MOD_W),
      .P45_MIN(P45_MIN),
      .P45_MAX(P45_MAX),
      .P89_MIN(P89_MIN),
      .P89_MAX(P89_MAX),
      .MOD_MIN(MOD_MIN)
   ) u_cfg_chk (
      .psel_i(psel_i),
      .int_i (int_i),
      .frac_i(frac_i),
      .mod_i (mod_i),
      .ok_o  (cfg_ok)
   );

   assign load_ok = load_i && cfg_ok;
   assign bypass  = imode_q && (frac_q == '0);
   assign step_en = !load_ok && !bypass;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [MOD_W-1:0] feed;
      if (g == 0) begin : g_head
         assign feed = frac_q;
      end else begin : g_tail
         assign feed = res_nxt[g-1];
      end
      fracn_acc_stage #(
         .MOD_W(MOD_W)
      ) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (load_ok),
         .adv_i  (step_en),
         .inc_i  (feed),
         .mod_i  (mod_q),
         .acc_o  (acc_q[g]),
         .res_o  (res_nxt[g]),
         .carry_o(carry[g])
      );
   end

   fracn_ofs_comb #(
      .ORDER(ORDER)
   ) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load_ok),
      .adv_i  (step_en),
      .carry_i(carry),
      .ofs_o  (ofs)
   );

   assign div_s = $signed({2'b00, int_q}) + $signed({{(DIV_W - 3){ofs[3]}}, ofs});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q   <= INT_W'(RST_INT);
         frac_q  <= '0;
         mod_q   <= MOD_W'(MOD_MIN);
         imode_q <= 1'b1;
         err_q   <= 1'b0;
         div_q   <= DIV_W'(RST_INT);
      end else begin
         if (load_i) err_q <= !cfg_ok;
         if (load_ok) begin
            int_q   <= int_i;
            frac_q  <= frac_i;
            mod_q   <= mod_i;
            imode_q <= imode_i;
            div_q   <= {1'b0, int_i};
         end else if (step_en) begin
            div_q <= div_s[DIV_W-1:0];
         end else begin
            div_q <= {1'b0, int_q};
         end
      end
   end

   assign div_o     = div_q;
   assign cfg_err_o = err_q;

endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
   parameter int INT_W   = 16,
   parameter int MOD_W   = 12,
   parameter int ORDER   = 3,
   parameter int P45_MIN = 23,
   parameter int P89_MIN = 75,
   parameter int MOD_MIN = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        load_i,
   input logic [INT_W:0]              div_o,
   input logic                        cfg_err_o,
   input logic [INT_W-1:0]            int_q,
   input logic [MOD_W-1:0]            frac_q,
   input logic [MOD_W-1:0]            mod_q,
   input logic                        imode_q,
   input logic [ORDER-1:0][MOD_W-1:0] acc_q
);
   localparam int INT_LO = (P45_MIN < P89_MIN) ? P45_MIN : P89_MIN;

   logic signed [INT_W+2:0] diff;
   assign diff = $signed({2'b00, div_o}) - $signed({3'b000, int_q});

   // R3
   ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diff >= -3) && (diff <= 4));

   for (genvar g = 0; g < ORDER; g++) begin : g_acc_chk
      // R3
      acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_q[g] < mod_q);
   end

   // R4
   int_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(int_q) >= INT_LO);

   // R5
   frac_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frac_q < mod_q);

   // R6
   mod_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mod_q) >= MOD_MIN);

   // R7
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!cfg_err_o || ($stable(int_q) && $stable(frac_q) && $stable(mod_q)
                                 && $stable(imode_q))));

   // R8
   bypass_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && imode_q && (frac_q == '0)) |=> (div_o == {1'b0, $past(int_q)}));

   // R9
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cfg_err_o || ((div_o == {1'b0, int_q}) && (acc_q == '0))));

   // R11
   err_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(cfg_err_o));

endmodule

bind fracn_divctl fracn_divctl_chk #(
   .INT_W  (INT_W),
   .MOD_W  (MOD_W),
   .ORDER  (ORDER),
   .P45_MIN(P45_MIN),
   .P89_MIN(P89_MIN),
   .MOD_MIN(MOD_MIN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_i   (load_i),
   .div_o    (div_o),
   .cfg_err_o(cfg_err_o),
   .int_q    (int_q),
   .frac_q   (frac_q),
   .mod_q    (mod_q),
   .imode_q  (imode_q),
   .acc_q    (acc_q)
);

// File: tb/fracn_divctl_tb.sv
module fracn_divctl_tb;
   localparam int PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic        load_i;
   logic        psel_i;
   logic        imode_i;
   logic [15:0] int_i;
   logic [11:0] frac_i;
   logic [11:0] mod_i;
   logic [16:0] div_o;
   logic        cfg_err_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit mon_en = 0;

   // behavioural model state
   int m_int, m_frac, m_mod, m_im;
   int a1, a2, a3, p2, p3a, p3b;
   int e_div, e_err;

   fracn_divctl u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .psel_i   (psel_i),
      .imode_i  (imode_i),
      .int_i    (int_i),
      .frac_i   (frac_i),
      .mod_i    (mod_i),
      .div_o    (div_o),
      .cfg_err_o(cfg_err_o)
   );

   initial clk = 1'b0;
   always #(PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit legal(input bit ps, input int i, input int f, input int m);
      int lo, hi;
      lo = ps ? 75 : 23;
      hi = ps ? 65535 : 32767;
      return (i >= lo) && (i <= hi) && (m >= 2) && (f < m);
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      int s, c1, c2, c3;
      if (!rst_n) begin
         m_int = 100; m_frac = 0; m_mod = 2; m_im = 1;
         a1 = 0; a2 = 0; a3 = 0; p2 = 0; p3a = 0; p3b = 0;
         e_div = 100; e_err = 0;
      end else if (load_i && legal(psel_i, int'(int_i), int'(frac_i), int'(mod_i))) begin
         m_int = int'(int_i); m_frac = int'(frac_i); m_mod = int'(mod_i); m_im = int'(imode_i);
         a1 = 0; a2 = 0; a3 = 0; p2 = 0; p3a = 0; p3b = 0;
         e_div = m_int; e_err = 0;
      end else begin
         if (load_i) e_err = 1;
         if (m_im == 1 && m_frac == 0) begin
            e_div = m_int;
         end else begin
            s = a1 + m_frac; c1 = (s >= m_mod) ? 1 : 0; a1 = s - c1 * m_mod;
            s = a2 + a1;     c2 = (s >= m_mod) ? 1 : 0; a2 = s - c2 * m_mod;
            s = a3 + a2;     c3 = (s >= m_mod) ? 1 : 0; a3 = s - c3 * m_mod;
            e_div = m_int + c1 + c2 - p2 + c3 - 2 * p3a + p3b;
            p3b = p3a; p3a = c3; p2 = c2;
         end
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (mon_en) begin
         chk(int'(div_o) == e_div, "R10 sequence", div_o, e_div);
         chk(int'(cfg_err_o) == e_err, "R11 error flag", cfg_err_o, e_err);
         chk((int'(div_o) >= m_int - 3) && (int'(div_o) <= m_int + 4), "R3 offset range", div_o, m_int);
      end
   end

   task automatic do_load(input bit ps, input bit im, input int i, input int f, input int m);
      @(negedge clk);
      psel_i  = ps;
      imode_i = im;
      int_i   = 16'(i);
      frac_i  = 12'(f);
      mod_i   = 12'(m);
      load_i  = 1'b1;
      @(negedge clk);
      load_i  = 1'b0;
   endtask

   task automatic sum_check(input int i, input int f, input int m);
      longint sum, expv, len;
      int varied;
      len = longint'(m) * m * m;
      sum = 0;
      varied = 0;
      repeat (2) @(negedge clk);
      for (longint k = 0; k < len; k++) begin
         @(negedge clk);
         sum += longint'(div_o);
         if (int'(div_o) != i) varied++;
      end
      expv = longint'(i) * len + longint'(f) * len / m;
      chk(sum == expv, "R1 average ratio", sum, expv);
      chk(varied > 0, "R8 dither active", varied, 1);
   endtask

   initial begin
      #(PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; load_i = 1'b0; psel_i = 1'b0; imode_i = 1'b0;
      int_i = '0; frac_i = '0; mod_i = '0;
      repeat (3) @(negedge clk);
      chk(div_o == 17'd100, "R2 reset divide", div_o, 100);
      chk(cfg_err_o == 1'b0, "R2 reset error", cfg_err_o, 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (5) @(negedge clk);
      chk(div_o == 17'd100, "R2 R8 default constant", div_o, 100);

      // R9 accepted load, R1 average
      do_load(1'b0, 1'b0, 23, 2, 5);
      chk(div_o == 17'd23, "R9 new INT", div_o, 23);
      chk(cfg_err_o == 1'b0, "R9 error clear", cfg_err_o, 0);
      sum_check(23, 2, 5);

      // R8 integer flag with non-zero FRAC still dithers; R1 second pattern
      do_load(1'b1, 1'b1, 1000, 3, 7);
      sum_check(1000, 3, 7);

      // R4 R6 upper corners
      do_load(1'b1, 1'b0, 65535, 4094, 4095);
      chk(div_o == 17'd65535, "R4 top INT", div_o, 65535);
      repeat (40) @(negedge clk);

      // R4 refused INT values
      do_load(1'b0, 1'b0, 22, 1, 3);
      chk(cfg_err_o == 1'b1, "R4 below 4/5 range", cfg_err_o, 1);
      do_load(1'b0, 1'b0, 32768, 1, 3);
      chk(cfg_err_o == 1'b1, "R4 above 4/5 range", cfg_err_o, 1);
      do_load(1'b1, 1'b0, 74, 1, 3);
      chk(cfg_err_o == 1'b1, "R4 below 8/9 range", cfg_err_o, 1);
      do_load(1'b0, 1'b0, 32767, 0, 2);
      chk(cfg_err_o == 1'b0, "R4 4/5 upper edge", cfg_err_o, 0);
      chk(div_o == 17'd32767, "R4 4/5 upper edge value", div_o, 32767);

      // R5 R7 refused FRAC, words kept
      do_load(1'b0, 1'b0, 500, 7, 7);
      chk(cfg_err_o == 1'b1, "R5 FRAC equal MOD", cfg_err_o, 1);
      repeat (5) @(negedge clk);
      chk(div_o == 17'd32767, "R7 words kept", div_o, 32767);
      chk(cfg_err_o == 1'b1, "R11 flag held", cfg_err_o, 1);

      // R6 refused MOD
      do_load(1'b0, 1'b0, 500, 0, 1);
      chk(cfg_err_o == 1'b1, "R6 MOD one", cfg_err_o, 1);
      do_load(1'b0, 1'b0, 500, 0, 0);
      chk(cfg_err_o == 1'b1, "R6 MOD zero", cfg_err_o, 1);

      // R12 inputs without strobe
      do_load(1'b0, 1'b0, 300, 2, 5);
      chk(div_o == 17'd300, "R9 reload", div_o, 300);
      @(negedge clk);
      psel_i = 1'b1; imode_i = 1'b1; int_i = 16'd40000; frac_i = 12'd0; mod_i = 12'd9;
      repeat (20) @(negedge clk);
      chk((div_o >= 17'd297) && (div_o <= 17'd304), "R12 inputs ignored", div_o, 300);

      // R8 integer-mode bypass
      do_load(1'b0, 1'b1, 500, 0, 9);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(div_o == 17'd500, "R8 bypass constant", div_o, 500);
      end

      // R7 refused strobe mid-sequence advances like an idle cycle
      do_load(1'b0, 1'b0, 300, 1, 3);
      repeat (4) @(negedge clk);
      do_load(1'b0, 1'b0, 10, 1, 3);
      chk(cfg_err_o == 1'b1, "R7 refused mid-run", cfg_err_o, 1);
      repeat (12) @(negedge clk);

      mon_en = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule